// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes received frames from a byte stream and lays them into a circular receive area of host memory. The area is a power of two in bytes. A frame begins with a start beat that carries its byte length and no data. Its data beats follow, and the final one is marked last.

On the start beat the block compares the room the frame needs with the room the host has left. Room left is the host's read pointer minus the block's write pointer, modulo the area size. If the frame fits, each data byte is stored four bytes past the frame's base. A one-word header (length and a good-frame flag) is then written at the base, and the write pointer moves to the next four-byte boundary. If the frame does not fit, nothing is written, an overflow interrupt bit is raised and a saturating missed-frame counter advances.

The memory port is word-wide with byte enables and byte addresses. Interrupt status bits are sticky and cleared by a write-one-to-clear strobe.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, wr_ptr, irq_status and missed_cnt are zero and mem_we is low.
- R2: On a start beat, avail = (host_rd_ptr - wr_ptr) mod 2^AW and need = frm_len + 8 rounded up to a multiple of 4. The frame is accepted when avail is 0 (empty area) or need < avail, and rejected otherwise.
- R3: A rejected frame writes no memory and leaves wr_ptr unchanged. From the cycle after its start beat, irq_status[1] (overflow) is set and missed_cnt is one higher.
- R4: For an accepted frame with base B, data byte i is written to address (B + 4 + i) mod 2^AW. mem_be has the single bit addr[1:0] set, and the byte is copied onto all four lanes of mem_wdata.
- R5: In the cycle after the last data beat, a header write is issued at address B with mem_be = 4'b1111. Its data is {frm_len[15:0], 15'b0, 1'b1}: length in bits 31:16, bit 0 is the good-frame flag.
- R6: From the cycle after the last data beat, wr_ptr equals (B + 4 + frm_len) rounded up to a multiple of 4, modulo 2^AW.
- R7: irq_status[0] (frame stored) is set from the cycle after the header write.
- R8: A high bit of irq_clr clears the matching irq_status bit at the next edge. If the same bit is set in that cycle, the set wins.
- R9: missed_cnt stops at all ones instead of wrapping.
- R10: A start beat in the same cycle as the previous frame's header write is judged against the already advanced wr_ptr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd_ptr | input | AW | Host read pointer into the receive area |
| frm_start | input | 1 | Start beat of a frame, carries frm_len |
| frm_len | input | 16 | Frame length in bytes, valid with frm_start |
| frm_valid | input | 1 | Data beat valid |
| frm_data | input | 8 | Data byte |
| frm_last | input | 1 | Marks the final data beat |
| irq_clr | input | 2 | Write-one-to-clear strobes for irq_status |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Byte address of the write |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| wr_ptr | output | AW | Current write pointer |
| irq_status | output | 2 | Bit 0 frame stored, bit 1 overflow |
| missed_cnt | output | CNT_W | Saturating count of rejected frames |

## Verification
Two functions can share a cycle: the header commit of a finished frame, and the space check of the next frame's start beat. That check must already see the advanced write pointer. The bench provokes this by sending every other frame with no idle cycle between frames. Each admission decision is then judged against a bench model whose pointer has moved first. A header-word check is made in the same cycle. A second coincidence is an overflow start beat during a clear strobe on the overflow bit. That bit must stay set.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int AW    = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    host_rd_ptr,
  input  logic             frm_start,
  input  logic [15:0]      frm_len,
  input  logic             frm_valid,
  input  logic [7:0]       frm_data,
  input  logic             frm_last,
  input  logic [1:0]       irq_clr,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  output logic [AW-1:0]    wr_ptr,
  output logic [1:0]       irq_status,
  output logic [CNT_W-1:0] missed_cnt
);
  localparam int NW = ((AW > 17) ? AW : 17) + 1;

  logic          acc, drop, hdr_pend;
  logic [AW-1:0] cur, hdr_addr;
  logic [15:0]   hdr_len;

  logic [AW-1:0] avail;
  logic [NW-1:0] need;
  logic          no_room, admit_ovf, take, missed_full;
  logic [AW-1:0] nxt, nxt_al;

  assign avail       = host_rd_ptr - wr_ptr;
  assign need        = (NW'(frm_len) + NW'(11)) & ~NW'(3);
  assign no_room     = (avail != '0) && (need >= NW'(avail));
  assign admit_ovf   = frm_start && no_room;
  assign take        = frm_valid && acc;
  assign missed_full = &missed_cnt;
  assign nxt         = cur + AW'(1);
  assign nxt_al      = (nxt + AW'(3)) & ~AW'(3);

  assign mem_we    = take || hdr_pend;
  assign mem_addr  = hdr_pend ? hdr_addr : cur;
  assign mem_be    = hdr_pend ? 4'hF : (4'b0001 << cur[1:0]);
  assign mem_wdata = hdr_pend ? {hdr_len, 15'd0, 1'b1} : {4{frm_data}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc        <= 1'b0;
      drop       <= 1'b0;
      hdr_pend   <= 1'b0;
      cur        <= '0;
      hdr_addr   <= '0;
      hdr_len    <= '0;
      wr_ptr     <= '0;
      irq_status <= '0;
      missed_cnt <= '0;
    end else begin
      hdr_pend <= take && frm_last;
      if (frm_start) begin
        acc  <= !no_room;
        drop <= no_room;
        if (!no_room) begin
          hdr_addr <= wr_ptr;
          hdr_len  <= frm_len;
          cur      <= wr_ptr + AW'(4);
        end
      end else if (take) begin
        cur <= nxt;
        if (frm_last) begin
          acc    <= 1'b0;
          wr_ptr <= nxt_al;
        end
      end else if (frm_valid && drop && frm_last) begin
        drop <= 1'b0;
      end
      if (admit_ovf && !missed_full) missed_cnt <= missed_cnt + CNT_W'(1);
      irq_status[0] <= hdr_pend  | (irq_status[0] & ~irq_clr[0]);
      irq_status[1] <= admit_ovf | (irq_status[1] & ~irq_clr[1]);
    end
  end

  // R3
  ovf_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    admit_ovf |=> !mem_we);
  // R3
  ovf_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    admit_ovf |=> ($stable(wr_ptr) && irq_status[1]));
  // R5
  hdr_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && frm_last) |=> (mem_we && mem_be == 4'hF && mem_addr[1:0] == 2'b00));
  // R7
  ok_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_be == 4'hF) |=> irq_status[0]);
  // R9
  missed_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    missed_full |=> missed_full);
endmodule

// File: tb/rx_ring_writer_tb.sv
module rx_ring_writer_tb;
  localparam int AW = 6;
  localparam int CW = 4;
  localparam int SZM = (1 << AW) - 1;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] host_rd_ptr = '0;
  logic frm_start = 1'b0;
  logic [15:0] frm_len = '0;
  logic frm_valid = 1'b0;
  logic [7:0] frm_data = '0;
  logic frm_last = 1'b0;
  logic [1:0] irq_clr = '0;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata;
  logic [AW-1:0] wr_ptr;
  logic [1:0] irq_status;
  logic [CW-1:0] missed_cnt;

  rx_ring_writer #(.AW(AW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_rd_ptr(host_rd_ptr),
    .frm_start(frm_start), .frm_len(frm_len), .frm_valid(frm_valid),
    .frm_data(frm_data), .frm_last(frm_last), .irq_clr(irq_clr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .wr_ptr(wr_ptr), .irq_status(irq_status),
    .missed_cnt(missed_cnt));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int wr_m = 0, miss_m = 0, fr_id = 0, widx = 0, bad = 0, exp_base = 0, ea = 0;
  bit b2b = 1'b0;

  function automatic logic [7:0] pat(input int f, input int i);
    return 8'((f * 13 + i * 7) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_we && mem_be != 4'hF) begin
      ea = (exp_base + 4 + widx) & SZM;
      if (int'(mem_addr) != ea || mem_be != (4'b0001 << (ea % 4)) ||
          mem_wdata[8*(ea%4) +: 8] != pat(fr_id, widx))
        bad++;
      widx++;
    end
  end

  task automatic run_frame(input int len, input int rd, input bit gap);
    int av, need, exp_wr;
    bit ovf;
    string rq;
    av   = (rd - wr_m) & SZM;
    need = (len + 11) & ~3;
    ovf  = (av != 0) && (need >= av);
    rq   = b2b ? "R10" : "R2";
    fr_id++;
    widx = 0;
    bad = 0;
    exp_base = wr_m;
    host_rd_ptr = AW'(rd);
    frm_start = 1'b1;
    frm_len = 16'(len);
    @(posedge clk); #1;
    frm_start = 1'b0;
    if (ovf) begin
      miss_m = (miss_m < CMAX) ? miss_m + 1 : CMAX;
      chk(int'(missed_cnt) == miss_m, "R3/R9 missed count", int'(missed_cnt), miss_m);
      chk(irq_status[1] == 1'b1, "R3 overflow irq", int'(irq_status[1]), 1);
    end
    for (int i = 0; i < len; i++) begin
      frm_valid = 1'b1;
      frm_data = pat(fr_id, i);
      frm_last = (i == len - 1);
      @(posedge clk); #1;
    end
    frm_valid = 1'b0;
    frm_last = 1'b0;
    if (!ovf) begin
      exp_wr = (wr_m + 4 + len + 3) & (SZM & ~3);
      chk(widx == len, {rq, " accept / R4 byte count"}, widx, len);
      chk(bad == 0, "R4 byte placement", bad, 0);
      chk(mem_we && mem_be == 4'hF && int'(mem_addr) == wr_m, "R5 header addr",
          int'(mem_addr), wr_m);
      chk(mem_wdata == {16'(len), 15'd0, 1'b1}, "R5 header data",
          int'(mem_wdata), int'({16'(len), 15'd0, 1'b1}));
      chk(int'(wr_ptr) == exp_wr, "R6 write pointer", int'(wr_ptr), exp_wr);
      wr_m = exp_wr;
    end else begin
      chk(widx == 0, {rq, " reject / R3 no writes"}, widx, 0);
      chk(int'(wr_ptr) == wr_m && !mem_we, "R3 pointer held", int'(wr_ptr), wr_m);
    end
    b2b = !gap;
    if (gap) begin
      @(posedge clk); #1;
      if (!ovf) chk(irq_status[0] == 1'b1, "R7 stored irq", int'(irq_status[0]), 1);
      irq_clr = 2'b11;
      @(posedge clk); #1;
      irq_clr = 2'b00;
      chk(irq_status == 2'b00, "R8 clear", int'(irq_status), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_ptr == '0 && irq_status == '0 && missed_cnt == '0 && !mem_we,
        "R1 reset state", int'(wr_ptr), 0);
    @(posedge clk); #1;
    for (int len = 1; len <= 48; len++) begin
      for (int k = 0; k < 5; k++) begin
        int need, rd;
        need = (len + 11) & ~3;
        case (k)
          0: rd = wr_m;
          1: rd = wr_m + need - 4;
          2: rd = wr_m + need;
          3: rd = wr_m + need + 1;
          default: rd = wr_m + need + 4;
        endcase
        run_frame(len, rd & SZM, ((len + k) % 2) == 1);
      end
    end
    @(posedge clk); #1;
    irq_clr = 2'b11;
    @(posedge clk); #1;
    irq_clr = 2'b00;
    chk(irq_status == 2'b00, "R8 idle clear", int'(irq_status), 0);
    host_rd_ptr = AW'((wr_m + 4) & SZM);
    frm_start = 1'b1;
    frm_len = 16'd1;
    irq_clr = 2'b10;
    @(posedge clk); #1;
    frm_start = 1'b0;
    irq_clr = 2'b00;
    chk(irq_status[1] == 1'b1, "R8 set wins over clear", int'(irq_status[1]), 1);
    chk(int'(missed_cnt) == CMAX, "R9 saturation", int'(missed_cnt), CMAX);
    frm_valid = 1'b1;
    frm_last = 1'b1;
    @(posedge clk); #1;
    frm_valid = 1'b0;
    frm_last = 1'b0;
    chk(!mem_we && int'(wr_ptr) == wr_m, "R3 dropped tail", int'(wr_ptr), wr_m);
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule